// File: doc/BRIEF.md
# Paged Memory-Map Decoder with Program/Data Space Swap

This block sits between a microcontroller's external bus and its memories. It takes a demultiplexed 18-bit address together with the type of the current bus cycle: instruction fetch, data read or data write. It drives one-hot selects for eight 16 KB flash sectors, a select for a 256-byte control window, and an active-low SRAM select. The sectors are grouped in two pages of four, and bit 0 of a paging register picks the page.

Two registers live inside the control window. The paging register carries the page bit. Its bit 7 withholds the SRAM select. The mapping register decides whether flash answers instruction fetches, data cycles, or both. Firmware can therefore rewrite its own code store in place while boot code keeps running from the internal region below 2000h.

The update sequence has four steps. First set paging bit 7. Then write 10h to the mapping register, so that data reads and writes reach flash and fetches do not. Next download the new code. Finally clear bit 7 and write 04h back to the mapping register.

A small cycle-tracking state machine classifies each clock as `CYC_IDLE`, `CYC_FETCH`, `CYC_READ` or `CYC_WRITE`. The class comes from the strobes, and exactly one strobe must be high for any class other than idle. The state moves every clock to the class of the current strobes. The transition out of `CYC_WRITE` into any other state is the commit edge, and on that edge the last write address and data update the registers.

Top module: `mem_map_decoder`

## Requirements
- R1: For a cycle enabled by the mapping register, an address in 2000h-FFFFh (bits 17..16 zero) selects exactly one flash sector. The ranges 2000h-5FFFh, 6000h-9FFFh, A000h-DFFFh and E000h-FFFFh select sector slots 0..3. The sector index is paging bit 0 times 4 plus the slot, and `flash_sel` bit n is sector n.
- R2: An instruction fetch below 2000h asserts no select of any kind.
- R3: A data read or write in 20000h-200FFh asserts `ctl_sel` whatever the paging value. Fetches never assert `ctl_sel`.
- R4: `sram_cs_n` is low for data cycles in 00000h-1FFFFh, but only while paging bit 7 is 0. While paging bit 7 is 1 it stays high.
- R5: In the mapping register, bit 4 lets data reads and writes reach flash and bit 2 lets fetches reach flash. Bit 0 lets fetches in 2000h-FFFFh reach the SRAM. Bits 7, 3 and 1 are stored but have no effect on decoding.
- R6: After reset the mapping register reads 04h and the paging register reads 00h.
- R7: A write cycle updates the paging register at window offset E0h or the mapping register at offset E2h when its strobe ends. A data read at those offsets returns the register. Any other offset reads 00h, and a write outside the window changes neither register.
- R8: `multi_sel_err` is high in any cycle where more than one of the flash, control and SRAM selects is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 18 | Demultiplexed bus address |
| fetch_stb | input | 1 | Instruction fetch strobe, active high |
| rd_stb | input | 1 | Data read strobe, active high |
| wr_stb | input | 1 | Data write strobe, active high |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register readback, 00h outside a register read |
| flash_sel | output | 8 | One-hot flash sector selects |
| ctl_sel | output | 1 | Control window select |
| sram_cs_n | output | 1 | SRAM select, active low |
| multi_sel_err | output | 1 | More than one select active |

## Verification
The embedded properties watch several invariants on every clock. Flash selects stay one-hot or zero. Fetches below the boot boundary stay silent. The SRAM stays off while paging bit 7 is set. A commit lasts one cycle, and the registers change only on a commit. The correctness of sector numbering across both pages, the readback values and the effect of each mapping code can only be shown by the bench's scenarios. The same holds for the reset contents, for the overlap fault when flash and SRAM both claim a data address, and for the full swap-and-restore sequence.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_FETCH = 2'd1,
        CYC_READ  = 2'd2,
        CYC_WRITE = 2'd3
    } cyc_state_e;

    // mapping register bit positions
    localparam int MAP_FL_DATA   = 4;
    localparam int MAP_FL_CODE   = 2;
    localparam int MAP_SRAM_CODE = 0;
    // paging register bit that withholds the SRAM select
    localparam int PAGE_SRAM_OFF = 7;

endpackage

// File: rtl/mmd_cycle_fsm.sv
module mmd_cycle_fsm
    import mmd_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_stb,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] wr_data,
    output cyc_state_e    cyc_cls,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);

    cyc_state_e state_q;
    cyc_state_e state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // classification of the present strobes: exactly one must be high
    always_comb begin
        unique case ({fetch_stb, rd_stb, wr_stb})
            3'b100:  cyc_cls = CYC_FETCH;
            3'b010:  cyc_cls = CYC_READ;
            3'b001:  cyc_cls = CYC_WRITE;
            default: cyc_cls = CYC_IDLE;
        endcase
    end

    always_comb begin
        state_d = cyc_cls;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cyc_cls == CYC_WRITE) begin
                addr_q <= bus_addr;
                data_q <= wr_data;
            end
        end
    end

    // outputs
    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            CYC_IDLE:  commit = 1'b0;
            CYC_FETCH: commit = 1'b0;
            CYC_READ:  commit = 1'b0;
            CYC_WRITE: commit = (state_d != CYC_WRITE);
        endcase
        commit_addr = addr_q;
        commit_data = data_q;
    end

    // R7: a commit never lasts more than one cycle
    p_commit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/mmd_ctrl_regs.sv
module mmd_ctrl_regs
    import mmd_pkg::*;
#(
    parameter int          AW        = 18,
    parameter int          DW        = 8,
    parameter logic [AW-1:0] CTL_BASE = 18'h20000,
    parameter logic [7:0]  PAGE_OFS  = 8'hE0,
    parameter logic [7:0]  MAP_OFS   = 8'hE2,
    parameter logic [DW-1:0] MAP_RST = 8'h04
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [AW-1:0] commit_addr,
    input  logic [DW-1:0] commit_data,
    input  cyc_state_e    cyc_cls,
    input  logic [AW-1:0] bus_addr,
    output logic [DW-1:0] page_q,
    output logic [DW-1:0] map_q,
    output logic [DW-1:0] rd_data
);

    logic wr_hit;
    logic rd_hit;

    always_comb begin
        wr_hit = commit && (commit_addr[AW-1:8] == CTL_BASE[AW-1:8]);
        rd_hit = (cyc_cls == CYC_READ) && (bus_addr[AW-1:8] == CTL_BASE[AW-1:8]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            map_q  <= MAP_RST;
        end else if (wr_hit) begin
            if (commit_addr[7:0] == PAGE_OFS) page_q <= commit_data;
            if (commit_addr[7:0] == MAP_OFS)  map_q  <= commit_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_hit) begin
            if (bus_addr[7:0] == PAGE_OFS)     rd_data = page_q;
            else if (bus_addr[7:0] == MAP_OFS) rd_data = map_q;
        end
    end

    // R7: registers hold unless a write commits
    p_regs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(page_q) && $stable(map_q)));

endmodule

// File: rtl/mmd_addr_decode.sv
module mmd_addr_decode
    import mmd_pkg::*;
#(
    parameter int            AW            = 18,
    parameter int            PROG_W        = 16,
    parameter int            NUM_SECT      = 8,
    parameter int            SECT_PER_PAGE = 4,
    parameter int            SECT_SHIFT    = 14,
    parameter logic [PROG_W-1:0] BOOT_TOP  = 16'h2000,
    parameter logic [AW-1:0] SRAM_TOP      = 18'h1FFFF,
    parameter logic [AW-1:0] CTL_BASE      = 18'h20000,
    localparam int IDX_W  = $clog2(NUM_SECT),
    localparam int SLOT_W = $clog2(SECT_PER_PAGE),
    localparam int PG_W   = IDX_W - SLOT_W
) (
    input  logic [AW-1:0]     bus_addr,
    input  cyc_state_e        cyc_cls,
    input  logic [PG_W-1:0]   page_bits,
    input  logic              sram_off,
    input  logic              fl_code_en,
    input  logic              fl_data_en,
    input  logic              sram_code_en,
    output logic [NUM_SECT-1:0] flash_sel,
    output logic              ctl_sel,
    output logic              sram_sel
);

    logic              is_fetch;
    logic              is_data;
    logic              in_prog;
    logic              above_boot;
    logic              flash_hit;
    logic [PROG_W-1:0] rel;
    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        is_fetch   = (cyc_cls == CYC_FETCH);
        is_data    = (cyc_cls == CYC_READ) || (cyc_cls == CYC_WRITE);
        in_prog    = (bus_addr[AW-1:PROG_W] == '0);
        above_boot = (bus_addr[PROG_W-1:0] >= BOOT_TOP);
        flash_hit  = in_prog && above_boot &&
                     ((is_fetch && fl_code_en) || (is_data && fl_data_en));
        rel        = bus_addr[PROG_W-1:0] - BOOT_TOP;
        slot       = SLOT_W'(rel >> SECT_SHIFT);
        idx        = {page_bits, slot};
        ctl_sel    = is_data && (bus_addr[AW-1:8] == CTL_BASE[AW-1:8]);
        sram_sel   = !sram_off &&
                     ((is_data && (bus_addr <= SRAM_TOP)) ||
                      (is_fetch && sram_code_en && in_prog && above_boot));
    end

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        assign flash_sel[g] = flash_hit && (idx == IDX_W'(g));
    end

endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
    import mmd_pkg::*;
#(
    parameter int AW       = 18,
    parameter int DW       = 8,
    parameter int NUM_SECT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic                fetch_stb,
    input  logic                rd_stb,
    input  logic                wr_stb,
    input  logic [DW-1:0]       wr_data,
    output logic [DW-1:0]       rd_data,
    output logic [NUM_SECT-1:0] flash_sel,
    output logic                ctl_sel,
    output logic                sram_cs_n,
    output logic                multi_sel_err
);

    localparam int SECT_PER_PAGE = 4;
    localparam int PG_W = $clog2(NUM_SECT) - $clog2(SECT_PER_PAGE);
    localparam int SEL_N = NUM_SECT + 2;

    cyc_state_e    cyc_cls;
    logic          commit;
    logic [AW-1:0] commit_addr;
    logic [DW-1:0] commit_data;
    logic [DW-1:0] page_q;
    logic [DW-1:0] map_q;
    logic          sram_sel;
    logic [SEL_N-1:0] all_sel;

    mmd_cycle_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .fetch_stb(fetch_stb), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .bus_addr(bus_addr), .wr_data(wr_data),
        .cyc_cls(cyc_cls), .commit(commit),
        .commit_addr(commit_addr), .commit_data(commit_data)
    );

    mmd_ctrl_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data),
        .cyc_cls(cyc_cls), .bus_addr(bus_addr),
        .page_q(page_q), .map_q(map_q), .rd_data(rd_data)
    );

    mmd_addr_decode #(.AW(AW), .NUM_SECT(NUM_SECT), .SECT_PER_PAGE(SECT_PER_PAGE)) u_dec (
        .bus_addr(bus_addr), .cyc_cls(cyc_cls),
        .page_bits(page_q[PG_W-1:0]),
        .sram_off(page_q[PAGE_SRAM_OFF]),
        .fl_code_en(map_q[MAP_FL_CODE]),
        .fl_data_en(map_q[MAP_FL_DATA]),
        .sram_code_en(map_q[MAP_SRAM_CODE]),
        .flash_sel(flash_sel), .ctl_sel(ctl_sel), .sram_sel(sram_sel)
    );

    always_comb begin
        sram_cs_n     = !sram_sel;
        all_sel       = {flash_sel, ctl_sel, sram_sel};
        multi_sel_err = ($countones(all_sel) > 1);
    end

    // R1: at most one flash sector at a time
    p_sector_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flash_sel));

    // R2: boot-region fetches stay off the external bus
    p_boot_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stb && !rd_stb && !wr_stb && (bus_addr < 18'h02000))
        |-> (flash_sel == '0 && !ctl_sel && sram_cs_n));

    // R4: SRAM withheld while paging bit 7 is set
    p_sram_withheld_r4: assert property (@(posedge clk) disable iff (!rst_n)
        page_q[PAGE_SRAM_OFF] |-> sram_cs_n);

    // R3: fetches never open the control window
    p_ctl_data_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stb && !rd_stb && !wr_stb) |-> !ctl_sel);

endmodule

// File: tb/mem_map_decoder_test.sv
module mem_map_decoder_test;

    typedef struct packed {
        logic [7:0] fl;
        logic       ctl;
        logic       sramn;
        logic       err;
        logic [7:0] rd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] bus_addr = '0;
    logic        fetch_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [7:0]  flash_sel;
    logic        ctl_sel;
    logic        sram_cs_n;
    logic        multi_sel_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    event  sample_ev;

    always #4 clk = ~clk;

    mem_map_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .fetch_stb(fetch_stb), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_data(rd_data), .flash_sel(flash_sel),
        .ctl_sel(ctl_sel), .sram_cs_n(sram_cs_n), .multi_sel_err(multi_sel_err)
    );

    // monitor: pops the expectation and compares with the outputs
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                exp_t  a;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = '{fl: flash_sel, ctl: ctl_sel, sramn: sram_cs_n,
                      err: multi_sel_err, rd: rd_data};
                n_tests++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: got fl=%h ctl=%b sram_n=%b err=%b rd=%h, expected fl=%h ctl=%b sram_n=%b err=%b rd=%h",
                             t, a.fl, a.ctl, a.sramn, a.err, a.rd,
                             e.fl, e.ctl, e.sramn, e.err, e.rd);
                end
            end
        end
    end

    task automatic probe(input logic f, input logic r, input logic [17:0] a,
                         input logic [7:0] fl, input logic c, input logic sn,
                         input logic er, input logic [7:0] rd, input string tag);
        @(negedge clk);
        fetch_stb = f; rd_stb = r; wr_stb = 1'b0; bus_addr = a;
        #1;
        exp_q.push_back('{fl: fl, ctl: c, sramn: sn, err: er, rd: rd});
        tag_q.push_back(tag);
        -> sample_ev;
        #1;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        fetch_stb = 1'b0; rd_stb = 1'b0;
        bus_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6 reset contents
        probe(0, 1, 18'h200E2, 8'h00, 1, 1, 0, 8'h04, "R6 map reset");
        probe(0, 1, 18'h200E0, 8'h00, 1, 1, 0, 8'h00, "R6 page reset");
        // R1 sectors on page 0
        probe(1, 0, 18'h02000, 8'h01, 0, 1, 0, 8'h00, "R1 slot0");
        probe(1, 0, 18'h06000, 8'h02, 0, 1, 0, 8'h00, "R1 slot1");
        probe(1, 0, 18'h0A000, 8'h04, 0, 1, 0, 8'h00, "R1 slot2");
        probe(1, 0, 18'h0FFFF, 8'h08, 0, 1, 0, 8'h00, "R1 slot3 top");
        probe(1, 0, 18'h05FFF, 8'h01, 0, 1, 0, 8'h00, "R1 slot0 top");
        // R2 boot region
        probe(1, 0, 18'h00000, 8'h00, 0, 1, 0, 8'h00, "R2 fetch 0");
        probe(1, 0, 18'h01FFF, 8'h00, 0, 1, 0, 8'h00, "R2 fetch 1FFF");
        // R4 SRAM data window
        probe(0, 1, 18'h04000, 8'h00, 0, 0, 0, 8'h00, "R4 sram read");
        probe(0, 1, 18'h1FFFF, 8'h00, 0, 0, 0, 8'h00, "R4 sram top");
        probe(0, 1, 18'h20100, 8'h00, 0, 1, 0, 8'h00, "R3 past window");
        // R7 page write, R1 page 1
        do_write(18'h200E0, 8'h01);
        probe(0, 1, 18'h200E0, 8'h00, 1, 1, 0, 8'h01, "R7 page readback");
        probe(1, 0, 18'h02000, 8'h10, 0, 1, 0, 8'h00, "R1 sector4");
        probe(1, 0, 18'h0E000, 8'h80, 0, 1, 0, 8'h00, "R1 sector7");
        probe(0, 1, 18'h200E4, 8'h00, 1, 1, 0, 8'h00, "R7 other offset");
        probe(0, 1, 18'h20055, 8'h00, 1, 1, 0, 8'h00, "R3 window page1");
        do_write(18'h010E0, 8'hFF);
        probe(0, 1, 18'h200E0, 8'h00, 1, 1, 0, 8'h01, "R7 write outside ignored");
        // R4 withhold SRAM
        do_write(18'h200E0, 8'h81);
        probe(0, 1, 18'h04000, 8'h00, 0, 1, 0, 8'h00, "R4 sram withheld");
        probe(0, 1, 18'h200E0, 8'h00, 1, 1, 0, 8'h81, "R3 window page81");
        // R5 swap flash into data space
        do_write(18'h200E2, 8'h10);
        probe(0, 1, 18'h04000, 8'h10, 0, 1, 0, 8'h00, "R5 data reaches flash");
        probe(1, 0, 18'h04000, 8'h00, 0, 1, 0, 8'h00, "R5 fetch blocked");
        probe(0, 1, 18'h200E2, 8'h00, 1, 1, 0, 8'h10, "R7 map readback");
        // R8 overlap when bit 7 cleared
        do_write(18'h200E0, 8'h01);
        probe(0, 1, 18'h04000, 8'h10, 0, 0, 1, 8'h00, "R8 flash+sram data");
        // R5 sram-in-code with R8 overlap
        do_write(18'h200E0, 8'h00);
        do_write(18'h200E2, 8'h05);
        probe(1, 0, 18'h02000, 8'h01, 0, 0, 1, 8'h00, "R8 flash+sram fetch");
        probe(1, 0, 18'h01000, 8'h00, 0, 1, 0, 8'h00, "R2 boot with sram code");
        // restore; R5 ignored bits
        do_write(18'h200E2, 8'h8E);
        probe(1, 0, 18'h02000, 8'h01, 0, 1, 0, 8'h00, "R5 unused bits no effect");
        probe(0, 1, 18'h04000, 8'h00, 0, 0, 0, 8'h00, "R5 data off flash");
        do_write(18'h200E2, 8'h04);
        probe(0, 1, 18'h200E2, 8'h00, 1, 1, 0, 8'h04, "R7 map restored");
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule